// File: doc/BRIEF.md
# Fixed-Delay Serial ADC Readout Controller

This block runs one conversion and readout on a successive-approximation converter whose busy line cannot be reached. A start request raises the convert line and holds it for a counted conversion time. The block takes no completion input. After that it produces a slow serial clock and shifts in a result word, MSB first. The length of that word comes from a device type code that is sampled at start.

The conversion wait and the serial clock half-period are cycle counts. Both are derived from the system clock frequency and from nanosecond parameters, rounded up. The result is zero-extended to 32 bits. A one-cycle done strobe marks the result as valid, and the result holds until the next accepted start. An unknown type code raises a one-cycle error strobe and does not start a transfer.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is held, and after it is released, cnv_o, sck_o, busy_o, done_o and err_o are all 0.
- R2: A start_i seen in idle with a valid type_i makes cnv_o and busy_o 1 on the next cycle, and sck_o stays 0.
- R3: cnv_o stays high for exactly CONV_CYC = ceil(CONV_NS*CLK_MHZ/1000) cycles. It then falls with sck_o low, and nothing else ends the wait.
- R4: type_i selects the frame length: code 0 gives 24 sck_o pulses, code 1 gives 16 and code 2 gives 18.
- R5: sdo_i is sampled at the clock edge where sck_o rises. The first sample lands in the MSB of the frame, and result_o bits above the frame length read 0.
- R6: Each sck_o low phase lasts HALF_CYC = ceil(HALF_NS*CLK_MHZ/1000) cycles, including the one between the fall of cnv_o and the first rise. Each high phase also lasts HALF_CYC cycles.
- R7: done_o pulses for exactly one cycle after the last sck_o high phase ends. busy_o falls in the cycle after that pulse, and result_o holds its value until the next accepted start.
- R8: type_i code 3 with start_i in idle gives a one-cycle err_o pulse on the next cycle, and busy_o and cnv_o stay 0.
- R9: A start_i seen while busy_o is 1 has no effect on the frame length, the timing or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and readout |
| type_i | input | 2 | Device type code (0: 24 bit, 1: 16 bit, 2: 18 bit) |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert line |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle result-valid strobe |
| err_o | output | 1 | One-cycle strobe for an unknown type code |
| result_o | output | 32 | Assembled result, zero-extended |

## Verification
The bench models the converter. It presents each bit after a rising serial clock, so a design that sampled on the wrong edge would return its words shifted by one place. Each frame carries patterns with a distinct MSB and LSB, so reversed bit order or a dropped final bit shows up at once. The bench counts clock pulses per type, which catches a frame length mapped to the wrong code. It measures the convert pulse and the phase widths, which exposes off-by-one counters. It sends a second start in mid-frame with another type, which would corrupt the result if busy starts were not ignored. Finally the unknown code must raise only the error strobe, with no convert pulse.

// File: rtl/adc_readout_pkg.sv
package adc_readout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } rd_state_e;

  localparam int unsigned LEN_W = 5;

  function automatic logic type_ok(input logic [1:0] t);
    return t != 2'd3;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] t);
    case (t)
      2'd0:    return LEN_W'(24);
      2'd1:    return LEN_W'(16);
      2'd2:    return LEN_W'(18);
      default: return LEN_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = load_val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i))); // R3

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (clr_i)           word_d = '0;
    else if (shift_en_i) word_d = {word_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && !clr_i) |=> (word_q[0] == $past(bit_i))); // R5

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_readout_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned CONV_NS = 1000,
  parameter int unsigned HALF_NS = 500,
  parameter int unsigned RES_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       type_i,
  input  logic             sdo_i,
  output logic             cnv_o,
  output logic             sck_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [RES_W-1:0] result_o
);

  localparam int unsigned CONV_CYC = (CONV_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned HALF_CYC = (HALF_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned MAX_CYC  = (CONV_CYC > HALF_CYC) ? CONV_CYC : HALF_CYC;
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] CONV_LD = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] HALF_LD = CW'(HALF_CYC - 1);

  rd_state_e        state_q, state_d;
  logic [LEN_W-1:0] bits_q, bits_d;
  logic [LEN_W-1:0] flen_q, flen_d;
  logic             err_q, err_d;
  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic             tmr_zero;
  logic             sh_clr, sh_en;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && start_i && type_ok(type_i);

  always_comb begin
    state_d  = state_q;
    bits_d   = bits_q;
    flen_d   = flen_q;
    err_d    = (state_q == ST_IDLE) && start_i && !type_ok(type_i);
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    sh_clr   = 1'b0;
    sh_en    = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_CONV;
        flen_d   = frame_len(type_i);
        bits_d   = frame_len(type_i);
        tmr_load = 1'b1;
        tmr_val  = CONV_LD;
        sh_clr   = 1'b1;
      end
      ST_CONV: if (tmr_zero) begin
        state_d  = ST_LOW;
        tmr_load = 1'b1;
      end
      ST_LOW: if (tmr_zero) begin
        state_d  = ST_HIGH;
        bits_d   = bits_q - 1'b1;
        sh_en    = 1'b1;
        tmr_load = 1'b1;
      end
      ST_HIGH: if (tmr_zero) begin
        state_d  = (bits_q == '0) ? ST_DONE : ST_LOW;
        tmr_load = (bits_q != '0);
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      flen_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      flen_q  <= flen_d;
      err_q   <= err_d;
    end
  end

  adc_rd_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  adc_rd_shifter #(.W(RES_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (sh_clr),
    .shift_en_i (sh_en),
    .bit_i      (sdo_i),
    .word_o     (result_o)
  );

  assign cnv_o  = (state_q == ST_CONV);
  assign sck_o  = (state_q == ST_HIGH);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = err_q;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy_o); // R1
  AST_CNV_SCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnv_o && sck_o)); // R2
  AST_CNV_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> (!sck_o && busy_o)); // R3
  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (bits_q <= flen_q)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R7
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !cnv_o)); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(flen_q)); // R9

endmodule

// File: tb/adc_readout_ctrl_test.sv
`timescale 1ns/1ps
module adc_readout_ctrl_test;

  localparam int unsigned CLK_MHZ  = 125;
  localparam int unsigned CONV_NS  = 1000;
  localparam int unsigned HALF_NS  = 500;
  localparam int unsigned CONV_CYC = (CONV_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned HALF_CYC = (HALF_NS * CLK_MHZ + 999) / 1000;
  localparam int NV = 6;

  typedef struct packed {
    logic [1:0]  typ;
    logic [31:0] data;
    logic [31:0] exp_res;
    logic [5:0]  width;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h00A5C396, 32'h00A5C396, 6'd24},
    '{2'd1, 32'h0000BEEF, 32'h0000BEEF, 6'd16},
    '{2'd2, 32'h0002AAA9, 32'h0002AAA9, 6'd18},
    '{2'd0, 32'h00FFFFFF, 32'h00FFFFFF, 6'd24},
    '{2'd1, 32'h00008001, 32'h00008001, 6'd16},
    '{2'd2, 32'h0003FFFE, 32'h0003FFFE, 6'd18}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] type_i = 2'd0;
  logic sdo_i = 1'b0;
  logic cnv_o, sck_o, busy_o, done_o, err_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails = 0;
  int sck_rises = 0;
  int cnv_len = 0, cnv_run = 0;
  int hi_run = 0, hi_len = 0;
  int lo_run = 0, lo_len = 0;

  always #4 clk = ~clk;

  adc_readout_ctrl #(.CLK_MHZ(CLK_MHZ), .CONV_NS(CONV_NS), .HALF_NS(HALF_NS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .type_i(type_i), .sdo_i(sdo_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .result_o(result_o)
  );

  // passive phase monitors, sampled at negedge
  always @(negedge clk) begin
    if (cnv_o) cnv_run++;
    else if (cnv_run != 0) begin cnv_len = cnv_run; cnv_run = 0; end
    if (sck_o) hi_run++;
    else if (hi_run != 0) begin hi_len = hi_run; hi_run = 0; end
    if (busy_o && !cnv_o && !sck_o && !done_o) lo_run++;
    else if (lo_run != 0) begin lo_len = lo_run; lo_run = 0; end
  end
  always @(posedge sck_o) sck_rises++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [1:0] t);
    @(negedge clk);
    start_i = 1'b1; type_i = t;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // runs one frame acting as the converter; optional mid-frame start with another type
  task automatic run_frame(input vec_t v, input logic poke);
    sck_rises = 0;
    pulse_start(v.typ);
    check("R2 cnv high after start", {31'd0, cnv_o}, 32'd1);
    check("R2 busy after start", {31'd0, busy_o}, 32'd1);
    check("R2 sck low after start", {31'd0, sck_o}, 32'd0);
    wait (!cnv_o);
    for (int i = int'(v.width) - 1; i >= 0; i--) begin
      sdo_i = v.data[i];
      if (poke && i == 3) begin
        start_i = 1'b1; type_i = (v.typ == 2'd0) ? 2'd1 : 2'd0;
      end
      @(posedge sck_o);
      #1;
      start_i = 1'b0;
    end
    sdo_i = 1'b0;
    for (int k = 0; k < 4 * HALF_CYC && !done_o; k++) @(negedge clk);
    check("R7 done pulse", {31'd0, done_o}, 32'd1);
    check("R5 result", result_o, v.exp_res);
    check("R4 sck pulse count", sck_rises, {26'd0, v.width});
    check("R3 cnv width", cnv_len, CONV_CYC);
    @(negedge clk);
    check("R7 done single", {31'd0, done_o}, 32'd0);
    check("R7 busy fell", {31'd0, busy_o}, 32'd0);
    check("R6 sck high width", hi_len, HALF_CYC);
    check("R6 sck low width", lo_len, HALF_CYC);
    repeat (3) @(negedge clk);
    check("R7 result held", result_o, v.exp_res);
  endtask

  initial begin : watchdog
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cnv", {31'd0, cnv_o}, 32'd0);
    check("R1 reset sck", {31'd0, sck_o}, 32'd0);
    check("R1 reset busy", {31'd0, busy_o}, 32'd0);
    check("R1 reset done", {31'd0, done_o}, 32'd0);
    check("R1 reset err", {31'd0, err_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", {31'd0, busy_o}, 32'd0);

    for (int n = 0; n < NV; n++) run_frame(VECS[n], 1'b0);

    // R8: unknown type code
    pulse_start(2'd3);
    check("R8 err pulse", {31'd0, err_o}, 32'd1);
    check("R8 no busy", {31'd0, busy_o}, 32'd0);
    check("R8 no cnv", {31'd0, cnv_o}, 32'd0);
    @(negedge clk);
    check("R8 err single", {31'd0, err_o}, 32'd0);
    check("R8 still idle", {31'd0, busy_o}, 32'd0);
    check("R8 result untouched", result_o, VECS[NV-1].exp_res);

    // R9: start during conversion wait and during shifting is ignored
    pulse_start(2'd0);
    pulse_start(2'd1);
    check("R9 cnv unbroken", {31'd0, cnv_o}, 32'd1);
    wait (!busy_o);
    @(negedge clk);
    run_frame('{2'd2, 32'h00024A53, 32'h00024A53, 6'd18}, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule